// File: doc/BRIEF.md
# JTAG Memory Access Bridge

This block is a JTAG test access port that lets an external debugger read and write system memory. Besides the usual identification and bypass instructions, it offers three memory instructions. One loads a word pointer. One streams words out of memory. One streams words out of memory while writing new words in their place. Each completed data scan advances the pointer by one word, so a debugger can walk a region with back-to-back scans.

Bus traffic runs on the system clock through a classic single-transfer Wishbone master. A toggle request/acknowledge handshake, with two-flop synchronizers in both directions, carries each access between the TCK domain and the system clock.

The design prefetches reads. Every Update-DR of a memory instruction ends with a bus read of the word at the new pointer. The next scan's Capture-DR loads that word into the shift register, so a scan always shifts out the word at the current pointer. The read result therefore belongs to the access launched one scan earlier. If an Update-DR arrives while the previous access is still unacknowledged, it is dropped.

Top module: `jtag_mem_bridge`

## Requirements
- R1: The TAP follows the 16-state controller. Five TCK cycles with TMS high reach Test-Logic-Reset, which makes IDCODE (code 1) the active instruction and clears the pointer to 0. Shift-IR always shifts out the capture pattern 3'b001 first, LSB first.
- R2: With the IDCODE instruction active, a DR scan shifts out the 32-bit ID_CODE parameter, LSB first.
- R3: Instruction codes 0, 2, 3 and 4 select a 1-bit bypass register. It captures 0, and TDI reappears on TDO one TCK later.
- R4: Code 5 selects the AW-bit pointer register. A scan shifts out the currently held pointer. Update-DR loads the shifted-in value and starts a read of that address.
- R5: Code 6 selects memory read. A scan shifts out the DW-bit word at the current pointer, and the shifted-in data are ignored: no write cycle is issued and memory is unchanged. Update-DR advances the pointer by one, wrapping modulo 2^AW, and reads the new address.
- R6: Code 7 selects read-and-write. A scan shifts out the word at the current pointer. Update-DR writes the shifted-in word to that address, then advances the pointer by one (wrapping) and reads the new address.
- R7: On the Wishbone side, STB is never high without CYC, and SEL is all ones. ADR, WE and DAT_O stay stable while STB is high and ACK is low. STB drops for at least one cycle after each ACK.
- R8: A code 7 update issues exactly one write cycle followed by one read cycle. A code 5 or code 6 update issues exactly one read cycle.
- R9: TDO is low outside Shift-DR and Shift-IR, and changes only on the falling edge of TCK.
- R10: While rst_n is low, the bus is idle and TDO is low. After reset the TAP is in Test-Logic-Reset, the instruction is IDCODE, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the bus master |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on the falling edge of TCK |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Transfer strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | AW | Word address |
| wb_dat_o | output | DW | Write data |
| wb_sel | output | DW/8 | Byte selects, all ones |
| wb_dat_i | input | DW | Read data |
| wb_ack | input | 1 | Transfer acknowledge |

## Verification
The bench builds the bridge with DW=8 and AW=5, a 32-word memory that it models itself. With this size, one read-and-write stream covers every address, continues past the last word and wraps back to word 0. A read stream from a mid-range start also crosses the wrap point. Each returned word is compared with an arithmetic fill pattern, and the number of write and read cycles per scan is counted. The narrow pointer also makes every pointer readback and the reset-cleared pointer easy to check exactly.

// File: rtl/jtag_mem_pkg.sv
// Shared types and codes for the JTAG memory bridge.
// Assumes a 3-bit instruction register; codes are fixed by the debugger's protocol.
package jtag_mem_pkg;

    typedef enum logic [3:0] {
        TAP_RESET, TAP_IDLE,
        DR_SELECT, DR_CAPTURE, DR_SHIFT, DR_EXIT1, DR_PAUSE, DR_EXIT2, DR_UPDATE,
        IR_SELECT, IR_CAPTURE, IR_SHIFT, IR_EXIT1, IR_PAUSE, IR_EXIT2, IR_UPDATE
    } tap_state_t;

    typedef enum logic [1:0] {
        BUS_IDLE, BUS_WRITE, BUS_GAP, BUS_READ
    } bus_state_t;

    localparam int          IR_W       = 3;
    localparam logic [2:0]  OP_IDCODE  = 3'd1;
    localparam logic [2:0]  OP_POINTER = 3'd5;
    localparam logic [2:0]  OP_FETCH   = 3'd6;
    localparam logic [2:0]  OP_SWAP    = 3'd7;
    localparam logic [2:0]  IR_CAP_PAT = 3'b001;

endpackage

// File: rtl/jtag_tap_ctrl.sv
// TAP controller: the 16-state machine advanced on rising TCK by TMS.
// Assumes rst_n is held low across at least one rising TCK edge.
module jtag_tap_ctrl
    import jtag_mem_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t state_nx;

    // Next-state decode from TMS.
    always_comb begin
        case (state)
            TAP_RESET:  state_nx = tms ? TAP_RESET : TAP_IDLE;
            TAP_IDLE:   state_nx = tms ? DR_SELECT : TAP_IDLE;
            DR_SELECT:  state_nx = tms ? IR_SELECT : DR_CAPTURE;
            DR_CAPTURE: state_nx = tms ? DR_EXIT1  : DR_SHIFT;
            DR_SHIFT:   state_nx = tms ? DR_EXIT1  : DR_SHIFT;
            DR_EXIT1:   state_nx = tms ? DR_UPDATE : DR_PAUSE;
            DR_PAUSE:   state_nx = tms ? DR_EXIT2  : DR_PAUSE;
            DR_EXIT2:   state_nx = tms ? DR_UPDATE : DR_SHIFT;
            DR_UPDATE:  state_nx = tms ? DR_SELECT : TAP_IDLE;
            IR_SELECT:  state_nx = tms ? TAP_RESET : IR_CAPTURE;
            IR_CAPTURE: state_nx = tms ? IR_EXIT1  : IR_SHIFT;
            IR_SHIFT:   state_nx = tms ? IR_EXIT1  : IR_SHIFT;
            IR_EXIT1:   state_nx = tms ? IR_UPDATE : IR_PAUSE;
            IR_PAUSE:   state_nx = tms ? IR_EXIT2  : IR_PAUSE;
            IR_EXIT2:   state_nx = tms ? IR_UPDATE : IR_SHIFT;
            IR_UPDATE:  state_nx = tms ? DR_SELECT : TAP_IDLE;
            default:    state_nx = TAP_RESET;
        endcase
    end

    // State register.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= TAP_RESET;
        else        state <= state_nx;
    end

endmodule

// File: rtl/jtag_dr_path.sv
// TCK-domain data path: instruction register, one shared data shift register,
// word pointer and request toggle toward the bus engine.
// Assumes read data from the system domain is stable whenever no request is pending.
module jtag_dr_path
    import jtag_mem_pkg::*;
#(
    parameter int          DW      = 64,
    parameter int          AW      = 32,
    parameter logic [31:0] ID_CODE = 32'h1357_9BDF
) (
    input  logic          tck,
    input  logic          rst_n,
    input  logic          tdi,
    input  tap_state_t    state,
    input  logic [DW-1:0] rdata,
    input  logic          ack_tgl,
    output logic          tdo,
    output logic [AW-1:0] addr_q,
    output logic [AW-1:0] wadr_q,
    output logic [DW-1:0] wdata_q,
    output logic          we_q,
    output logic          req_tgl
);

    localparam int WIDE = (DW > AW) ? DW : AW;
    localparam int SRW  = (WIDE > 32) ? WIDE : 32;

    logic [IR_W-1:0] ir_q, ir_sr;
    logic [SRW-1:0]  sr, sr_nx, cap_val;
    logic [SRW:0]    sr_ext;
    logic [1:0]      ack_sync;
    logic            pending;
    int              len;

    assign pending = req_tgl ^ ack_sync[1];
    assign sr_ext  = {1'b0, sr};

    // Selected data register length and capture value per instruction.
    always_comb begin
        case (ir_q)
            OP_POINTER:       begin len = AW; cap_val = SRW'(addr_q);  end
            OP_FETCH, OP_SWAP:begin len = DW; cap_val = SRW'(rdata);   end
            OP_IDCODE:        begin len = 32; cap_val = SRW'(ID_CODE); end
            default:          begin len = 1;  cap_val = '0;            end
        endcase
    end

    // One shift step: TDI enters at the top bit of the selected length.
    always_comb begin
        for (int i = 0; i < SRW; i++) begin
            if (i == len - 1)     sr_nx[i] = tdi;
            else if (i < len - 1) sr_nx[i] = sr_ext[i+1];
            else                  sr_nx[i] = 1'b0;
        end
    end

    // Data shift register: capture and shift.
    always_ff @(posedge tck) begin
        if (!rst_n)                  sr <= '0;
        else if (state == DR_CAPTURE) sr <= cap_val;
        else if (state == DR_SHIFT)   sr <= sr_nx;
    end

    // Instruction register: capture pattern, shift, update, reset to IDCODE.
    always_ff @(posedge tck) begin
        if (!rst_n || state == TAP_RESET) begin
            ir_sr <= IR_CAP_PAT;
            ir_q  <= OP_IDCODE;
        end else if (state == IR_CAPTURE) begin
            ir_sr <= IR_CAP_PAT;
        end else if (state == IR_SHIFT) begin
            ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        end else if (state == IR_UPDATE) begin
            ir_q  <= ir_sr;
        end
    end

    // Acknowledge toggle synchronizer from the system clock.
    always_ff @(posedge tck) begin
        if (!rst_n) ack_sync <= '0;
        else        ack_sync <= {ack_sync[0], ack_tgl};
    end

    // Pointer update and access launch on Update-DR of a memory instruction.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wadr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            req_tgl <= 1'b0;
        end else if (state == TAP_RESET) begin
            addr_q  <= '0;
        end else if (state == DR_UPDATE && !pending) begin
            case (ir_q)
                OP_POINTER: begin
                    addr_q  <= sr[AW-1:0];
                    we_q    <= 1'b0;
                    req_tgl <= ~req_tgl;
                end
                OP_FETCH: begin
                    addr_q  <= addr_q + 1'b1;
                    we_q    <= 1'b0;
                    req_tgl <= ~req_tgl;
                end
                OP_SWAP: begin
                    wadr_q  <= addr_q;
                    wdata_q <= sr[DW-1:0];
                    addr_q  <= addr_q + 1'b1;
                    we_q    <= 1'b1;
                    req_tgl <= ~req_tgl;
                end
                default: ;
            endcase
        end
    end

    // TDO driven on the falling edge, low outside the shift states.
    always_ff @(negedge tck) begin
        if (!rst_n)                 tdo <= 1'b0;
        else if (state == DR_SHIFT) tdo <= sr[0];
        else if (state == IR_SHIFT) tdo <= ir_sr[0];
        else                        tdo <= 1'b0;
    end

endmodule

// File: rtl/wb_access_engine.sv
// System-clock bus engine: on each request toggle it runs an optional write
// cycle, one idle cycle, then a read cycle, and returns an acknowledge toggle.
// Assumes the request payload is stable until the acknowledge toggle returns.
module wb_access_engine
    import jtag_mem_pkg::*;
#(
    parameter int DW = 64,
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_tgl,
    input  logic              we,
    input  logic [AW-1:0]     wadr,
    input  logic [DW-1:0]     wdata,
    input  logic [AW-1:0]     radr,
    output logic [DW-1:0]     rdata,
    output logic              ack_tgl,
    output logic              wb_cyc,
    output logic              wb_stb,
    output logic              wb_we,
    output logic [AW-1:0]     wb_adr,
    output logic [DW-1:0]     wb_dat_o,
    output logic [DW/8-1:0]   wb_sel,
    input  logic [DW-1:0]     wb_dat_i,
    input  logic              wb_ack
);

    bus_state_t bst;
    logic [2:0] req_sync;
    logic       start;

    assign start = req_sync[2] ^ req_sync[1];

    // Request toggle synchronizer plus edge-detect stage.
    always_ff @(posedge clk) begin
        if (!rst_n) req_sync <= '0;
        else        req_sync <= {req_sync[1:0], req_tgl};
    end

    // Bus sequencer: write, gap, read, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bst     <= BUS_IDLE;
            rdata   <= '0;
            ack_tgl <= 1'b0;
        end else begin
            case (bst)
                BUS_IDLE:  if (start) bst <= we ? BUS_WRITE : BUS_READ;
                BUS_WRITE: if (wb_ack) bst <= BUS_GAP;
                BUS_GAP:   bst <= BUS_READ;
                BUS_READ:  if (wb_ack) begin
                               rdata   <= wb_dat_i;
                               ack_tgl <= ~ack_tgl;
                               bst     <= BUS_IDLE;
                           end
                default:   bst <= BUS_IDLE;
            endcase
        end
    end

    // Bus outputs decoded from the sequencer state.
    always_comb begin
        wb_cyc   = (bst == BUS_WRITE) || (bst == BUS_READ);
        wb_stb   = wb_cyc;
        wb_we    = (bst == BUS_WRITE);
        wb_adr   = (bst == BUS_WRITE) ? wadr : radr;
        wb_dat_o = wdata;
        wb_sel   = '1;
    end

endmodule

// File: rtl/jtag_mem_bridge.sv
// Top: JTAG TAP with pointer, read and read-and-write data registers driving
// a single-transfer Wishbone master on the system clock.
// Assumes TCK runs well below clk and rst_n spans edges of both clocks.
module jtag_mem_bridge
    import jtag_mem_pkg::*;
#(
    parameter int          DW      = 64,
    parameter int          AW      = 32,
    parameter logic [31:0] ID_CODE = 32'h1357_9BDF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tck,
    input  logic            tms,
    input  logic            tdi,
    output logic            tdo,
    output logic            wb_cyc,
    output logic            wb_stb,
    output logic            wb_we,
    output logic [AW-1:0]   wb_adr,
    output logic [DW-1:0]   wb_dat_o,
    output logic [DW/8-1:0] wb_sel,
    input  logic [DW-1:0]   wb_dat_i,
    input  logic            wb_ack
);

    tap_state_t    tap_state;
    logic [AW-1:0] addr_q, wadr_q;
    logic [DW-1:0] wdata_q, rdata;
    logic          we_q, req_tgl, ack_tgl;

    jtag_tap_ctrl u_tap (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (tap_state)
    );

    jtag_dr_path #(.DW(DW), .AW(AW), .ID_CODE(ID_CODE)) u_dr (
        .tck     (tck),
        .rst_n   (rst_n),
        .tdi     (tdi),
        .state   (tap_state),
        .rdata   (rdata),
        .ack_tgl (ack_tgl),
        .tdo     (tdo),
        .addr_q  (addr_q),
        .wadr_q  (wadr_q),
        .wdata_q (wdata_q),
        .we_q    (we_q),
        .req_tgl (req_tgl)
    );

    wb_access_engine #(.DW(DW), .AW(AW)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_tgl  (req_tgl),
        .we       (we_q),
        .wadr     (wadr_q),
        .wdata    (wdata_q),
        .radr     (addr_q),
        .rdata    (rdata),
        .ack_tgl  (ack_tgl),
        .wb_cyc   (wb_cyc),
        .wb_stb   (wb_stb),
        .wb_we    (wb_we),
        .wb_adr   (wb_adr),
        .wb_dat_o (wb_dat_o),
        .wb_sel   (wb_sel),
        .wb_dat_i (wb_dat_i),
        .wb_ack   (wb_ack)
    );

endmodule

// File: rtl/jtag_mem_bridge_chk.sv
// Protocol checker for the JTAG memory bridge, bound into the top module.
module jtag_mem_bridge_chk
    import jtag_mem_pkg::*;
#(
    parameter int DW = 64,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          tck,
    input logic          rst_n,
    input tap_state_t    tap_state,
    input logic          tdo,
    input logic [AW-1:0] addr_q,
    input logic          wb_cyc,
    input logic          wb_stb,
    input logic          wb_we,
    input logic [AW-1:0] wb_adr,
    input logic [DW-1:0] wb_dat_o,
    input logic          wb_ack
);

    AST_STB_WITHIN_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        wb_stb |-> wb_cyc);  // R7

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && !wb_ack) |=> (wb_stb && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dat_o)));  // R7

    AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && wb_ack) |=> !wb_stb);  // R7

    AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_stb && wb_we && wb_ack) |=> ##1 (wb_stb && !wb_we));  // R8

    AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state != DR_SHIFT && tap_state != IR_SHIFT) |-> !tdo);  // R9

    AST_RESET_CLEARS_PTR: assert property (@(posedge tck) disable iff (!rst_n)
        (tap_state == TAP_RESET) |=> (addr_q == '0));  // R1

endmodule

bind jtag_mem_bridge jtag_mem_bridge_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .tck       (tck),
    .rst_n     (rst_n),
    .tap_state (tap_state),
    .tdo       (tdo),
    .addr_q    (addr_q),
    .wb_cyc    (wb_cyc),
    .wb_stb    (wb_stb),
    .wb_we     (wb_we),
    .wb_adr    (wb_adr),
    .wb_dat_o  (wb_dat_o),
    .wb_ack    (wb_ack)
);

// File: tb/jtag_mem_bridge_test.sv
// Bench: drives the TAP serially, models a 32-word memory on the bus side,
// and compares every shifted-out word with arithmetic expectations.
module jtag_mem_bridge_test;

    localparam int          DW    = 8;
    localparam int          AW    = 5;
    localparam int          WORDS = 1 << AW;
    localparam int          SELW  = DW / 8;
    localparam logic [31:0] IDC   = 32'h2468_ACE1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            tck = 1'b0;
    logic            tms = 1'b1;
    logic            tdi = 1'b0;
    logic            tdo;
    logic            wb_cyc, wb_stb, wb_we;
    logic [AW-1:0]   wb_adr;
    logic [DW-1:0]   wb_dat_o;
    logic [SELW-1:0] wb_sel;
    logic [DW-1:0]   wb_dat_i;
    logic            wb_ack;

    logic [DW-1:0]   mem [WORDS];
    int              vecs = 0;
    int              fails = 0;
    int              wr_cnt = 0;
    int              rd_cnt = 0;
    bit              done = 1'b0;

    jtag_mem_bridge #(.DW(DW), .AW(AW), .ID_CODE(IDC)) uut (
        .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
        .wb_dat_o(wb_dat_o), .wb_sel(wb_sel), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] fill_val(input int i);
        return DW'(i * 11 + 3);
    endfunction

    function automatic logic [DW-1:0] put_val(input int k);
        return DW'(k * 37 + 5);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One TCK period: set TMS/TDI, sample TDO just before the rising edge.
    task automatic tclk(input logic m, input logic d, output logic o);
        tms = m; tdi = d;
        #40; o = tdo;
        tck = 1'b1; #50;
        tck = 1'b0; #10;
    endtask

    task automatic idle(input int n, output logic o);
        for (int i = 0; i < n; i++) tclk(1'b0, 1'b0, o);
    endtask

    task automatic scan_dr(input int len, input logic [63:0] din, output logic [63:0] dout);
        logic o;
        dout = '0;
        tclk(1'b1, 1'b0, o);
        tclk(1'b0, 1'b0, o);
        tclk(1'b0, 1'b0, o);
        for (int i = 0; i < len; i++) begin
            tclk(i == len - 1, din[i], o);
            dout[i] = o;
        end
        tclk(1'b1, 1'b0, o);
        tclk(1'b0, 1'b0, o);
        idle(10, o);
        check("R9 tdo idle", 64'(o), 64'd0);
    endtask

    task automatic scan_ir(input logic [2:0] code, output logic [2:0] cap);
        logic o;
        tclk(1'b1, 1'b0, o);
        tclk(1'b1, 1'b0, o);
        tclk(1'b0, 1'b0, o);
        tclk(1'b0, 1'b0, o);
        for (int i = 0; i < 3; i++) begin
            tclk(i == 2, code[i], o);
            cap[i] = o;
        end
        tclk(1'b1, 1'b0, o);
        tclk(1'b0, 1'b0, o);
        idle(2, o);
    endtask

    // Memory model: acknowledges each strobe half a cycle later.
    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = fill_val(i);
        wb_ack = 1'b0;
        wb_dat_i = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                wb_ack = 1'b0;
            end else if (wb_cyc && wb_stb && !wb_ack) begin
                check("R7 sel all ones", 64'(wb_sel), 64'({SELW{1'b1}}));
                if (wb_we) begin
                    mem[wb_adr] = wb_dat_o;
                    wr_cnt++;
                end else begin
                    wb_dat_i = mem[wb_adr];
                    rd_cnt++;
                end
                wb_ack = 1'b1;
            end else begin
                wb_ack = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        #1500000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] dout;
        logic [2:0]  cap;
        logic        o;
        int          w0, r0;

        // R10: reset holds bus idle and TDO low.
        repeat (3) begin
            #50 tck = 1'b1; #50 tck = 1'b0;
        end
        #3;
        check("R10 bus idle in reset", 64'({wb_cyc, wb_stb}), 64'd0);
        check("R10 tdo low in reset", 64'(tdo), 64'd0);
        #20 rst_n = 1'b1;
        #30;

        // R10/R2: IDCODE active straight after reset.
        tclk(1'b0, 1'b0, o);
        scan_dr(32, 64'h0, dout);
        check("R2 R10 idcode after reset", dout, 64'(IDC));

        // R1: IR capture pattern; R3 bypass for each bypass code.
        for (int c = 0; c < 5; c++) begin
            if (c != 1) begin
                scan_ir(3'(c), cap);
                check("R1 ir capture", 64'(cap), 64'b001);
                scan_dr(8, 64'hB6, dout);
                check("R3 bypass delay", dout[7:0], 64'({8'hB6} << 1) & 64'hFF);
            end
        end

        // R4/R10: pointer reads back 0 after reset, then load 0.
        scan_ir(3'd5, cap);
        scan_dr(AW, 64'd0, dout);
        check("R4 R10 pointer after reset", dout, 64'd0);

        // R6/R8: read-and-write stream across every word and the wrap.
        scan_ir(3'd7, cap);
        for (int k = 0; k <= WORDS; k++) begin
            w0 = wr_cnt; r0 = rd_cnt;
            scan_dr(DW, 64'(put_val(k)), dout);
            check("R6 swap returns old word", dout,
                  64'((k < WORDS) ? fill_val(k) : put_val(k - WORDS)));
            check("R8 swap one write one read", 64'({16'(wr_cnt - w0), 16'(rd_cnt - r0)}),
                  64'({16'd1, 16'd1}));
        end

        // R4: pointer has wrapped to 1; load 29.
        scan_ir(3'd5, cap);
        scan_dr(AW, 64'd29, dout);
        check("R4 pointer readback", dout, 64'd1);

        // R5: read stream with junk input, crossing the wrap.
        scan_ir(3'd6, cap);
        for (int j = 0; j < WORDS; j++) begin
            int idx;
            idx = (29 + j) % WORDS;
            w0 = wr_cnt; r0 = rd_cnt;
            scan_dr(DW, 64'hFF, dout);
            check("R5 fetch word", dout, 64'((idx == 0) ? put_val(WORDS) : put_val(idx)));
            check("R8 fetch one read no write", 64'({16'(wr_cnt - w0), 16'(rd_cnt - r0)}),
                  64'({16'd0, 16'd1}));
        end
        for (int i = 0; i < WORDS; i++)
            check("R5 memory untouched", 64'(mem[i]),
                  64'((i == 0) ? put_val(WORDS) : put_val(i)));

        // R4: pointer back at 29 after a full lap.
        scan_ir(3'd5, cap);
        scan_dr(AW, 64'd7, dout);
        check("R4 pointer after lap", dout, 64'd29);

        // R1: Test-Logic-Reset restores IDCODE and clears the pointer.
        for (int i = 0; i < 5; i++) tclk(1'b1, 1'b0, o);
        tclk(1'b0, 1'b0, o);
        scan_dr(32, 64'h0, dout);
        check("R1 idcode after tlr", dout, 64'(IDC));
        scan_ir(3'd5, cap);
        check("R1 ir capture", 64'(cap), 64'b001);
        scan_dr(AW, 64'd3, dout);
        check("R1 pointer cleared by tlr", dout, 64'd0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule